// File: doc/BRIEF.md
# Approximate Array Multiplier

This block multiplies two unsigned 8-bit pixel values into a 16-bit product. All partial products are formed with AND gates. A carry-save array then folds them, row after row, through full-adder cells. The running sum and carry vectors leave each row of cells and feed the next row. A final exact carry-propagate adder merges the two vectors that remain.

A 2-bit mode input picks the full-adder flavour that every cell of the array uses. The choice can be exact, a minority-style cell whose sum is the complement of its carry, or a cell whose carry simply follows its partial-product input. Trading precision for cheaper cells in this way suits image arithmetic, where small numeric errors are hard to see. The mode is meant to be held static while the block works, but it is sampled together with the operands, so a change takes effect on the next product. The product is registered by default, with a synchronous active-high reset. A parameter removes the register and gives a purely combinational path.

Top module: `amul_array_mult`

## Requirements
- R1: With mode 00, the product equals op_a * op_b exactly, as an unsigned 16-bit value, for all 65,536 operand pairs.
- R2: Mode 11 gives results identical to mode 00.
- R3: The partial-product bit for op_a[j] and op_b[i] has weight i+j. The array starts with sum vector S = op_a if op_b[0] is 1, else 0, and carry vector C = 0. For each row i from 1 to 7 and each j from 0 to 7, one cell at column w = i+j takes A = that partial-product bit, B = S[w] and Cin = C[w]. It writes its sum to S[w] and its carry to the new C[w+1]. Bits of S that the row does not touch are kept, and the new C is zero elsewhere. All 56 cells use the selected mode.
- R4: In mode 01 each cell's carry is the majority of A, B and Cin, and its sum is the inverse of that carry. The sum is therefore wrong only for inputs 000 and 111, a total cell error distance of 2.
- R5: In mode 10 each cell's carry equals its A input and its sum is the exact parity of A, B and Cin. The carry is therefore wrong only when B equals Cin and differs from A.
- R6: The final S and C vectors are added with an exact adder, so all error comes from the array cells.
- R7: Because cells with all-zero inputs output a sum of 1 in mode 01, the product in mode 01 is 32766 for 0*0 and 32767 for 1*1. In mode 10, 0*0 gives 0 and 1*1 gives 1.
- R8: With the output register enabled, the product reflects the operands and mode present at the previous rising clock edge. A high reset at a rising edge makes the product 0 after that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| cell_mode | input | 2 | Cell flavour: 00 exact, 01 minority, 10 carry-follows-A, 11 exact |
| product | output | 16 | Unsigned product |

## Verification
In exact mode, a sweep covers every operand pair. A misrouted partial product or a wrong carry column would shift weight between bits and break many products. The approximate modes are compared against an independent model of the array from R3. That comparison catches a swapped A/B role in the carry-follows-A cell, which would change which cases are in error. Directed zero and unit operands in mode 01 expose whether idle cells really emit a sum of 1. A design that skipped cells with constant-zero inputs would return 0 instead of 32766 for 0*0. A runtime mode switch and a reset asserted with nonzero operands check that the register takes the new mode on the very next edge and clears regardless of the inputs.

// File: rtl/amul_pkg.sv
package amul_pkg;

    typedef enum logic [1:0] {
        CELL_EXACT  = 2'b00,
        CELL_MINOR  = 2'b01,
        CELL_CARRYA = 2'b10,
        CELL_ALT    = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/amul_fa_cell.sv
module amul_fa_cell
    import amul_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       in_c,
    output fa_out_t    res
);

    always_comb begin
        logic    mj;
        logic    par;
        fa_out_t r;
        mj  = maj3(in_a, in_b, in_c);
        par = in_a ^ in_b ^ in_c;
        case (mode)
            CELL_MINOR:  r = '{carry: mj,   sum: ~mj};
            CELL_CARRYA: r = '{carry: in_a, sum: par};
            default:     r = '{carry: mj,   sum: par};
        endcase
        res = r;

        if (!$isunknown({mode, in_a, in_b, in_c})) begin
            // R4
            min_err_chk: assert (!(mode == CELL_MINOR && r.sum != (in_a ^ in_b ^ in_c))
                                 || (in_a == in_b && in_b == in_c))
                else $error("minority cell sum error outside 000/111");
            // R5
            carrya_err_chk: assert (!(mode == CELL_CARRYA && r.carry != maj3(in_a, in_b, in_c))
                                    || (in_b == in_c && in_b != in_a))
                else $error("carry-follows-A cell error outside B==Cin!=A");
            // R1 R2
            exact_cell_chk: assert (!(mode == CELL_EXACT || mode == CELL_ALT)
                                    || ({r.carry, r.sum} == 2'(in_a) + 2'(in_b) + 2'(in_c)))
                else $error("exact cell arithmetic wrong");
        end
    end

endmodule

// File: rtl/amul_csa_row.sv
module amul_csa_row
    import amul_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned ROW = 1,
    localparam int unsigned PW = 2 * W
) (
    input  cell_mode_e      mode,
    input  logic [W-1:0]    pp_row,
    input  logic [PW-1:0]   s_in,
    input  logic [PW-1:0]   c_in,
    output logic [PW-1:0]   s_out,
    output logic [PW-1:0]   c_out
);

    fa_out_t cell_res [W];

    for (genvar j = 0; j < W; j++) begin : g_cell
        amul_fa_cell u_cell (
            .mode (mode),
            .in_a (pp_row[j]),
            .in_b (s_in[ROW + j]),
            .in_c (c_in[ROW + j]),
            .res  (cell_res[j])
        );
    end

    always_comb begin
        s_out = s_in;
        c_out = '0;
        for (int j = 0; j < W; j++) begin
            s_out[ROW + j]     = cell_res[j].sum;
            c_out[ROW + j + 1] = cell_res[j].carry;
        end
    end

endmodule

// File: rtl/amul_ripple.sv
module amul_ripple #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] sum
);

    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int k = 0; k < N; k++) begin
            sum[k] = x[k] ^ y[k] ^ cy;
            cy     = (x[k] & y[k]) | (x[k] & cy) | (y[k] & cy);
        end
    end

endmodule

// File: rtl/amul_array_mult.sv
module amul_array_mult
    import amul_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned PW     = 2 * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [1:0]    cell_mode,
    output logic [PW-1:0] product
);

    cell_mode_e    mode;
    logic [W-1:0]  pp    [W];
    logic [PW-1:0] s_vec [W];
    logic [PW-1:0] c_vec [W];
    logic [PW-1:0] prod_comb;

    assign mode = cell_mode_e'(cell_mode);

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = op_a & {W{op_b[i]}};
    end

    assign s_vec[0] = {{W{1'b0}}, pp[0]};
    assign c_vec[0] = '0;

    for (genvar r = 1; r < W; r++) begin : g_row
        amul_csa_row #(.W(W), .ROW(r)) u_row (
            .mode   (mode),
            .pp_row (pp[r]),
            .s_in   (s_vec[r-1]),
            .c_in   (c_vec[r-1]),
            .s_out  (s_vec[r]),
            .c_out  (c_vec[r])
        );
    end

    amul_ripple #(.N(PW)) u_final (
        .x   (s_vec[W-1]),
        .y   (c_vec[W-1]),
        .sum (prod_comb)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) product <= '0;
            else     product <= prod_comb;
        end

        // R8
        rst_clear_chk: assert property (@(posedge clk) rst |=> product == '0)
            else $error("product not cleared by reset");

        // R1 R2
        exact_prod_chk: assert property (@(posedge clk) disable iff (rst)
            (cell_mode == 2'b00 || cell_mode == 2'b11)
            |=> product == PW'($past(op_a)) * PW'($past(op_b)))
            else $error("exact-mode product wrong");
    end else begin : g_comb
        assign product = prod_comb;
    end

endmodule

// File: tb/sim_amul_array_mult.sv
module sim_amul_array_mult;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_a = 8'd0;
    logic [7:0]  op_b = 8'd0;
    logic [1:0]  cell_mode = 2'b00;
    logic [15:0] product;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    amul_array_mult u0 (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .cell_mode (cell_mode),
        .product   (product)
    );

    // Operand pairs with their exact products.
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {8'd0,   8'd0,   16'd0},
        {8'd1,   8'd1,   16'd1},
        {8'd255, 8'd255, 16'd65025},
        {8'd255, 8'd1,   16'd255},
        {8'd1,   8'd255, 16'd255},
        {8'd128, 8'd128, 16'd16384},
        {8'd170, 8'd85,  16'd14450},
        {8'd85,  8'd170, 16'd14450},
        {8'd15,  8'd240, 16'd3600},
        {8'd200, 8'd3,   16'd600},
        {8'd17,  8'd19,  16'd323},
        {8'd0,   8'd99,  16'd0}
    };

    // Array model following R3 with cell rules of R4/R5.
    function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic [1:0] m);
        logic [15:0] s, c, ns, nc;
        logic x, y, z, mj, cr, sm;
        s = {8'd0, a & {8{b[0]}}};
        c = '0;
        for (int i = 1; i < 8; i++) begin
            ns = s;
            nc = '0;
            for (int j = 0; j < 8; j++) begin
                x  = a[j] & b[i];
                y  = s[i + j];
                z  = c[i + j];
                mj = (x & y) | (x & z) | (y & z);
                case (m)
                    2'b01:   begin cr = mj; sm = ~mj;      end
                    2'b10:   begin cr = x;  sm = x ^ y ^ z; end
                    default: begin cr = mj; sm = x ^ y ^ z; end
                endcase
                ns[i + j]     = sm;
                nc[i + j + 1] = cr;
            end
            s = ns;
            c = nc;
        end
        return s + c;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_cmp++;
        if (product !== exp) begin
            n_bad++;
            $display("FAIL %s: product=%0d expected=%0d (a=%0d b=%0d mode=%0d)",
                     tag, product, exp, op_a, op_b, cell_mode);
        end
    endtask

    // Called at a negedge: drive, let one posedge capture, sample at next negedge.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [1:0] m);
        op_a = a;
        op_b = b;
        cell_mode = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        real ed_sum [4];
        foreach (ed_sum[k]) ed_sum[k] = 0.0;

        // R8: reset state
        op_a = 8'd200; op_b = 8'd200;
        repeat (3) @(negedge clk);
        check("R8 reset state", 16'd0);
        rst = 1'b0;

        // Table walk over all modes (R1 R2 exact, R3 R4 R5 model)
        for (int v = 0; v < NV; v++) begin
            for (int m = 0; m < 4; m++) begin
                apply(VEC[v][31:24], VEC[v][23:16], 2'(m));
                if (m == 0)      check("R1 table", VEC[v][15:0]);
                else if (m == 3) check("R2 table", VEC[v][15:0]);
                else if (m == 1) check("R4 R3 table", model(VEC[v][31:24], VEC[v][23:16], 2'(m)));
                else             check("R5 R3 table", model(VEC[v][31:24], VEC[v][23:16], 2'(m)));
            end
        end

        // R7: idle cells emit sum 1 in minority mode
        apply(8'd0, 8'd0, 2'b01); check("R7 0*0 minority", 16'd32766);
        apply(8'd1, 8'd1, 2'b01); check("R7 1*1 minority", 16'd32767);
        apply(8'd0, 8'd0, 2'b10); check("R7 0*0 carry-A", 16'd0);
        apply(8'd1, 8'd1, 2'b10); check("R7 1*1 carry-A", 16'd1);

        // R8: runtime mode switch takes effect on the next edge
        apply(8'd0, 8'd0, 2'b00); check("R8 switch to exact", 16'd0);
        apply(8'd0, 8'd0, 2'b01); check("R8 switch to minority", 16'd32766);

        // R8: reset clears with nonzero operands
        rst = 1'b1;
        apply(8'd250, 8'd251, 2'b00); check("R8 mid-run reset", 16'd0);
        rst = 1'b0;

        // R1 R6: exhaustive exact sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b), 2'b00);
                check("R1 R6 sweep", 16'(a * b));
            end
        end

        // R2 R4 R5: strided sweeps of the other modes, with mean error distance
        for (int m = 1; m < 4; m++) begin
            for (int a = 0; a < 256; a += 4) begin
                for (int b = 1; b < 256; b += 4) begin
                    logic [15:0] exp_v;
                    int          ed;
                    exp_v = (m == 3) ? 16'(a * b) : model(8'(a), 8'(b), 2'(m));
                    apply(8'(a), 8'(b), 2'(m));
                    if (m == 1)      check("R4 sweep", exp_v);
                    else if (m == 2) check("R5 sweep", exp_v);
                    else             check("R2 sweep", exp_v);
                    ed = int'(product) - (a * b);
                    if (ed < 0) ed = -ed;
                    ed_sum[m] += real'(ed);
                end
            end
            $display("mode %0d mean error distance vs exact product: %f",
                     m, ed_sum[m] / 4096.0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule